// File: doc/BRIEF.md
# Converter Result Capture Sequencer

This block walks a small programmable list of 8-bit instruction words and moves converter results into a byte-addressed data memory. Each instruction names the converter results to capture. The sequencer waits until every named result has arrived. It then writes each result as a high byte followed by a low byte, at consecutive addresses. A per-instruction repeat counter re-runs the same instruction a set number of times before the list pointer moves on. A word with bits 6:0 all zero marks the end of the list. Its bit 7 chooses between two outcomes: jump back to the first instruction and keep going, or stop.

Software loads the list through a write port. It then sets the first list index, the repeat count and the memory base address, and raises the enable input. Two converter ports deliver 16-bit results, each marked by a one-cycle valid pulse. Writes leave on a single byte-wide port that has no back-pressure.

Top module: `adc_dma_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are all 0.
- R2: When `cfg_en` is high, the block is idle and `done` is 0, the block starts. It raises `busy`, begins at list index `cfg_start_ptr`, and writes its first byte at `cfg_mem_base`. Every later write goes to the next address (+1). This holds across list wrap-around.
- R3: In an instruction word, bit 4 selects converter 0 and bit 5 selects converter 1. For each selected converter the block writes the high byte (data[15:8]) and then the low byte (data[7:0]). When both are selected, converter 0's two bytes come first.
- R4: Bit 6 selects differential capture. It takes converter 0's result only, even when bit 5 is also set.
- R5: Each non-terminating instruction runs max(L,1) passes, where L is `cfg_rpt_limit`. The counter then reloads and the list index advances by one.
- R6: The list index is 6 bits wide and advances from 63 to 0.
- R7: A terminating word (bits 6:0 = 0) with bit 7 = 0 stops the block. `busy` goes to 0 and `done` goes to 1. `done` holds, and the block stays idle, until `cfg_en` goes low. `done` then returns to 0.
- R8: A terminating word with bit 7 = 1 sends the list index back to `cfg_start_ptr` and keeps running. The write address is not reset.
- R9: A valid pulse from a converter that the current instruction does not select leaves the written data unchanged.
- R10: A selected result that arrives while another result is still pending or being written is held in a one-entry register and written afterwards.
- R11: When `cfg_en` is low at the next instruction fetch, the block aborts: `busy` goes to 0 and `done` stays 0. A new start reloads the repeat counter (a full L passes again), the list index and the write address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_en | input | 1 | Run enable |
| cfg_start_ptr | input | 6 | First list index, and the index that wrap-around returns to |
| cfg_rpt_limit | input | 16 | Passes per instruction |
| cfg_mem_base | input | 16 | First data-memory byte address |
| ibuf_we | input | 1 | Instruction list write strobe |
| ibuf_waddr | input | 6 | Instruction list write index |
| ibuf_wdata | input | 8 | Instruction word |
| cnv0_valid | input | 1 | Converter 0 result pulse |
| cnv0_data | input | 16 | Converter 0 result |
| cnv1_valid | input | 1 | Converter 1 result pulse |
| cnv1_data | input | 16 | Converter 1 result |
| mem_we | output | 1 | Data-memory byte write |
| mem_addr | output | 16 | Data-memory byte address |
| mem_wdata | output | 8 | Data-memory byte |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sequence halted on a stop word |

## Verification
A wrong repeat count or list index shows up on `mem_we` after the next pass. The write pattern then no longer matches the instruction expected at that point. Bytes appear that nobody expected, or expected bytes never arrive within the pass timeout. A bad write address or a bad byte order is visible in the very cycle of the faulty write. A wrongly held or dropped converter result shows up within the same pass, as a stale or missing byte. Faults in the stop and abort paths appear on `busy` and `done` a few cycles after the final write.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RUN} seq_state_e;

   typedef struct packed {
      logic cont;
      logic eoo;
      logic use0;
      logic use1;
   } instr_dec_t;

   function automatic instr_dec_t decode_word(input logic [7:0] w);
      instr_dec_t d;
      d.cont = w[7];
      d.eoo  = (w[6:0] == 7'd0);
      d.use0 = w[4] | w[6];
      d.use1 = w[5] & ~w[6];
      return d;
   endfunction

endpackage

// File: rtl/adc_dma_ibuf.sv
module adc_dma_ibuf #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int WW    = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [WW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [WW-1:0] rdata
);

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("adc_dma_ibuf: DEPTH must equal 2**AW");
      end
   endgenerate

   logic [WW-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= wdata;
   end

   assign rdata = words[raddr];

endmodule

// File: rtl/adc_dma_slot.sv
module adc_dma_slot #(
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          new_pass,
   input  logic          armed,
   input  logic          in_valid,
   input  logic [SW-1:0] in_data,
   input  logic          consume,
   output logic          full,
   output logic [SW-1:0] data
);

   logic got_q;
   logic load;

   assign load = armed & in_valid & ~got_q & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_q <= 1'b0;
         full  <= 1'b0;
         data  <= '0;
      end else begin
         if (new_pass) got_q <= 1'b0;
         else if (load) got_q <= 1'b1;
         if (load) begin
            full <= 1'b1;
            data <= in_data;
         end else if (consume) begin
            full <= 1'b0;
         end
      end
   end

   assert_slot_consume_R10: assert property (@(posedge clk) disable iff (!rst_n)
      consume |-> full);

   assert_slot_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !armed && !consume) |=> (full == $past(full)));

endmodule

// File: rtl/adc_dma_rpt.sv
module adc_dma_rpt #(
   parameter int RPT_W = 16,
   parameter int PW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic             eoo_wrap,
   input  logic             pass_end,
   input  logic [PW-1:0]    start_ptr,
   input  logic [RPT_W-1:0] limit,
   output logic [PW-1:0]    ptr,
   output logic [RPT_W-1:0] cnt
);

   localparam logic [RPT_W-1:0] ONE = RPT_W'(1);

   generate
      if (RPT_W < 2) begin : g_bad_rpt
         $error("adc_dma_rpt: RPT_W must be at least 2");
      end
   endgenerate

   logic last_pass;
   assign last_pass = (cnt <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         cnt <= '0;
      end else if (reload || eoo_wrap) begin
         ptr <= start_ptr;
         cnt <= limit;
      end else if (pass_end) begin
         if (last_pass) begin
            cnt <= limit;
            ptr <= ptr + 1'b1;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   assert_repeat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_end && !last_pass && !reload && !eoo_wrap) |=> $stable(ptr));

   assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_end && last_pass && !reload && !eoo_wrap) |=> (ptr == PW'($past(ptr) + 1'b1)));

   assert_eoo_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoo_wrap |=> (ptr == $past(start_ptr)));

endmodule

// File: rtl/adc_dma_seq.sv
module adc_dma_seq
   import adc_dma_pkg::*;
#(
   parameter int IBUF_DEPTH = 64,
   parameter int MADDR_W    = 16,
   parameter int RPT_W      = 16,
   parameter int BYTE_W     = 8,
   localparam int IPTR_W    = $clog2(IBUF_DEPTH),
   localparam int SAMP_W    = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic [IPTR_W-1:0] cfg_start_ptr,
   input  logic [RPT_W-1:0]  cfg_rpt_limit,
   input  logic [MADDR_W-1:0] cfg_mem_base,
   input  logic              ibuf_we,
   input  logic [IPTR_W-1:0] ibuf_waddr,
   input  logic [7:0]        ibuf_wdata,
   input  logic              cnv0_valid,
   input  logic [SAMP_W-1:0] cnv0_data,
   input  logic              cnv1_valid,
   input  logic [SAMP_W-1:0] cnv1_data,
   output logic              mem_we,
   output logic [MADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done
);

   localparam int NCONV = 2;

   generate
      if (IBUF_DEPTH < 2 || IBUF_DEPTH != (1 << IPTR_W)) begin : g_bad_ibuf
         $error("adc_dma_seq: IBUF_DEPTH must be a power of two");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("adc_dma_seq: BYTE_W must be positive");
      end
   endgenerate

   seq_state_e        state_q;
   logic              done_q;
   instr_dec_t        cur_q;
   instr_dec_t        fet_dec;
   logic [1:0]        step_q;
   logic [MADDR_W-1:0] waddr_q;
   logic [IPTR_W-1:0] ptr;
   logic [RPT_W-1:0]  cnt;
   logic [7:0]        ibuf_rd;

   logic in_idle, in_fetch, in_run;
   logic fetch_eoo, fetch_noop;
   logic wr_fire, last_byte, pass_end;
   logic cur_c;
   logic [SAMP_W-1:0] cur_sample;
   logic [BYTE_W-1:0] wr_byte;

   logic              vld_v   [NCONV];
   logic [SAMP_W-1:0] din_v   [NCONV];
   logic              arm_v   [NCONV];
   logic              cons_v  [NCONV];
   logic              full_v  [NCONV];
   logic [SAMP_W-1:0] sdata_v [NCONV];

   assign in_idle  = (state_q == ST_IDLE);
   assign in_fetch = (state_q == ST_FETCH);
   assign in_run   = (state_q == ST_RUN);

   adc_dma_ibuf #(.DEPTH(IBUF_DEPTH), .AW(IPTR_W), .WW(8)) u_ibuf (
      .clk   (clk),
      .we    (ibuf_we),
      .waddr (ibuf_waddr),
      .wdata (ibuf_wdata),
      .raddr (ptr),
      .rdata (ibuf_rd)
   );

   assign fet_dec    = decode_word(ibuf_rd);
   assign fetch_eoo  = in_fetch & cfg_en & fet_dec.eoo;
   assign fetch_noop = in_fetch & cfg_en & ~fet_dec.eoo & ~fet_dec.use0 & ~fet_dec.use1;

   assign vld_v[0] = cnv0_valid;
   assign vld_v[1] = cnv1_valid;
   assign din_v[0] = cnv0_data;
   assign din_v[1] = cnv1_data;
   assign arm_v[0] = in_run & cur_q.use0;
   assign arm_v[1] = in_run & cur_q.use1;

   genvar c;
   generate
      for (c = 0; c < NCONV; c++) begin : g_slot
         assign cons_v[c] = wr_fire & step_q[0] & (step_q[1] == c[0]);
         adc_dma_slot #(.SW(SAMP_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .new_pass (in_fetch),
            .armed    (arm_v[c]),
            .in_valid (vld_v[c]),
            .in_data  (din_v[c]),
            .consume  (cons_v[c]),
            .full     (full_v[c]),
            .data     (sdata_v[c])
         );
      end
   endgenerate

   assign cur_c      = step_q[1];
   assign cur_sample = sdata_v[cur_c];
   assign wr_fire    = in_run & full_v[cur_c];
   assign wr_byte    = step_q[0] ? cur_sample[BYTE_W-1:0] : cur_sample[SAMP_W-1:BYTE_W];
   assign last_byte  = wr_fire & step_q[0] & (step_q[1] | ~cur_q.use1);
   assign pass_end   = last_byte | fetch_noop;

   adc_dma_rpt #(.RPT_W(RPT_W), .PW(IPTR_W)) u_rpt (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload    (in_idle),
      .eoo_wrap  (fetch_eoo),
      .pass_end  (pass_end),
      .start_ptr (cfg_start_ptr),
      .limit     (cfg_rpt_limit),
      .ptr       (ptr),
      .cnt       (cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         done_q    <= 1'b0;
         cur_q     <= '0;
         step_q    <= 2'd0;
         waddr_q   <= '0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= wr_fire;
         if (wr_fire) begin
            mem_addr  <= waddr_q;
            mem_wdata <= wr_byte;
            waddr_q   <= waddr_q + 1'b1;
         end
         case (state_q)
            ST_IDLE: begin
               if (!cfg_en) begin
                  done_q <= 1'b0;
               end else if (!done_q) begin
                  state_q <= ST_FETCH;
                  waddr_q <= cfg_mem_base;
               end
            end
            ST_FETCH: begin
               if (!cfg_en) begin
                  state_q <= ST_IDLE;
               end else if (fet_dec.eoo) begin
                  if (!fet_dec.cont) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end else if (fet_dec.use0 || fet_dec.use1) begin
                  cur_q   <= fet_dec;
                  step_q  <= fet_dec.use0 ? 2'd0 : 2'd2;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (wr_fire) begin
                  if (last_byte) state_q <= ST_FETCH;
                  else if (step_q == 2'd1) step_q <= 2'd2;
                  else step_q <= step_q + 2'd1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = ~in_idle;
   assign done = done_q;

   assert_wr_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == MADDR_W'($past(mem_addr) + 1'b1)));

   assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_fetch && !cfg_en) |=> (!busy && !done));

endmodule

// File: tb/adc_dma_seq_bench.sv
module adc_dma_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic [5:0]  cfg_start_ptr = '0;
   logic [15:0] cfg_rpt_limit = '0;
   logic [15:0] cfg_mem_base = '0;
   logic        ibuf_we = 1'b0;
   logic [5:0]  ibuf_waddr = '0;
   logic [7:0]  ibuf_wdata = '0;
   logic        cnv0_valid = 1'b0;
   logic [15:0] cnv0_data = '0;
   logic        cnv1_valid = 1'b0;
   logic [15:0] cnv1_data = '0;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        busy;
   logic        done;

   int n_run  = 0;
   int n_fail = 0;
   logic [15:0] exp_addr;
   logic [15:0] qa [$];
   logic [7:0]  qd [$];
   string       qt [$];

   always #2.5 clk = ~clk;

   adc_dma_seq u_adc_dma_seq (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_start_ptr(cfg_start_ptr),
      .cfg_rpt_limit(cfg_rpt_limit), .cfg_mem_base(cfg_mem_base),
      .ibuf_we(ibuf_we), .ibuf_waddr(ibuf_waddr), .ibuf_wdata(ibuf_wdata),
      .cnv0_valid(cnv0_valid), .cnv0_data(cnv0_data),
      .cnv1_valid(cnv1_valid), .cnv1_data(cnv1_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .busy(busy), .done(done)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pop and compare every byte the block writes
   always @(negedge clk) begin
      if (rst_n && mem_we === 1'b1) begin
         n_run++;
         if (qa.size() == 0) begin
            n_fail++;
            $display("FAIL R9 unexpected write actual=%0h@%0h expected=none", mem_wdata, mem_addr);
         end else begin
            if (mem_addr !== qa[0] || mem_wdata !== qd[0]) begin
               n_fail++;
               $display("FAIL %s actual=%0h@%0h expected=%0h@%0h",
                        qt[0], mem_wdata, mem_addr, qd[0], qa[0]);
            end
            void'(qa.pop_front());
            void'(qd.pop_front());
            void'(qt.pop_front());
         end
      end
   end

   task automatic push_sample(input logic [15:0] s, input string tag);
      qa.push_back(exp_addr);     qd.push_back(s[15:8]); qt.push_back(tag);
      qa.push_back(exp_addr + 1); qd.push_back(s[7:0]);  qt.push_back(tag);
      exp_addr = exp_addr + 2;
   endtask

   task automatic ib_wr(input logic [5:0] a, input logic [7:0] w);
      @(negedge clk);
      ibuf_we = 1'b1; ibuf_waddr = a; ibuf_wdata = w;
      @(negedge clk);
      ibuf_we = 1'b0;
   endtask

   // driver: pulse converters, push expected bytes, wait for the pass to drain
   task automatic feed(input bit p0, input bit p1, input logic [15:0] d0, input logic [15:0] d1,
                       input bit e0, input bit e1, input int gap, input string tag);
      repeat (5) @(posedge clk);
      if (e0) push_sample(d0, tag);
      if (e1) push_sample(d1, tag);
      @(negedge clk);
      cnv0_data = d0; cnv1_data = d1;
      if (gap == 0) begin
         cnv0_valid = p0; cnv1_valid = p1;
         @(negedge clk);
         cnv0_valid = 1'b0; cnv1_valid = 1'b0;
      end else begin
         cnv1_valid = p1;
         @(negedge clk);
         cnv1_valid = 1'b0;
         repeat (gap) @(negedge clk);
         cnv0_valid = p0;
         @(negedge clk);
         cnv0_valid = 1'b0;
      end
      for (int i = 0; i < 60 && qa.size() > 0; i++) @(negedge clk);
      n_run++;
      if (qa.size() != 0) begin
         n_fail++;
         $display("FAIL %s pending writes actual=%0d expected=0", tag, qa.size());
         qa.delete(); qd.delete(); qt.delete();
      end
   endtask

   task automatic start_run(input logic [5:0] sp, input logic [15:0] lim, input logic [15:0] base);
      @(negedge clk);
      cfg_start_ptr = sp; cfg_rpt_limit = lim; cfg_mem_base = base;
      @(negedge clk);
      exp_addr = base;
      cfg_en = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 mem_we", mem_we, 0);

      // Test A: list at 4, two passes each, stop at end
      ib_wr(6'd4, 8'h10);
      ib_wr(6'd5, 8'h30);
      ib_wr(6'd6, 8'h00);
      start_run(6'd4, 16'd2, 16'h0100);
      repeat (2) @(negedge clk);
      check("R2 busy", busy, 1);
      feed(1, 1, 16'hA1B2, 16'hDEAD, 1, 0, 0, "R9 unselected conv1");
      feed(1, 0, 16'hC3D4, 16'h0000, 1, 0, 0, "R5 second pass");
      feed(1, 1, 16'h1122, 16'h3344, 1, 1, 0, "R10 both together");
      feed(1, 1, 16'h5566, 16'h7788, 1, 1, 2, "R3 conv1 early");
      repeat (5) @(negedge clk);
      check("R7 busy", busy, 0);
      check("R7 done", done, 1);
      repeat (10) @(negedge clk);
      check("R7 held idle", busy, 0);
      cfg_en = 1'b0;
      repeat (2) @(negedge clk);
      check("R7 done clear", done, 0);

      // Test B: wrap 63->0, differential, continuous, limit 0, abort
      ib_wr(6'd62, 8'h60);
      ib_wr(6'd63, 8'h20);
      ib_wr(6'd0,  8'h80);
      start_run(6'd62, 16'd0, 16'h0200);
      feed(1, 1, 16'h0F0E, 16'hBEEF, 1, 0, 0, "R4 differential");
      feed(1, 1, 16'hCAFE, 16'h2468, 0, 1, 0, "R6 index 63");
      feed(1, 1, 16'h1357, 16'h9999, 1, 0, 0, "R8 continuous wrap");
      cfg_en = 1'b0;
      feed(0, 1, 16'h0000, 16'hABCD, 0, 1, 0, "R11 finish pass");
      repeat (5) @(negedge clk);
      check("R11 abort busy", busy, 0);
      check("R11 abort done", done, 0);

      // Test C: abort mid-repeat, restart gets full count
      ib_wr(6'd10, 8'h10);
      ib_wr(6'd11, 8'h00);
      start_run(6'd10, 16'd3, 16'h0300);
      feed(1, 0, 16'h0101, 16'h0000, 1, 0, 0, "R11 pass 1");
      cfg_en = 1'b0;
      feed(1, 0, 16'h0202, 16'h0000, 1, 0, 0, "R11 pass 2");
      repeat (5) @(negedge clk);
      check("R11 idle", busy, 0);
      start_run(6'd10, 16'd3, 16'h0300);
      feed(1, 0, 16'h0A0A, 16'h0000, 1, 0, 0, "R11 restart 1");
      feed(1, 0, 16'h0B0B, 16'h0000, 1, 0, 0, "R11 restart 2");
      feed(1, 0, 16'h0C0C, 16'h0000, 1, 0, 0, "R5 restart 3");
      repeat (5) @(negedge clk);
      check("R5 done after three", done, 1);
      cfg_en = 1'b0;
      repeat (3) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule